// File: doc/BRIEF.md
# Logical Device I/O Base Decoder

This block watches host I/O cycles and decides whether each one falls into the address window of one of two logical devices. The first device owns a 128-byte window of runtime registers. The second device owns a two-byte port pair: the lower byte is the data port and the upper byte is the status/command port. Software places each window by writing a 16-bit base address as a high byte and a low byte through the configuration space. It then enables the device with an activation bit.

For every valid cycle the decoder raises at most one select strobe and gives the offset of the access inside the selected window. Each base is forced onto its device's alignment boundary when it is written. A base that lies outside the device's permitted range turns decoding off for that device. Only address bits 11 to 0 are compared against a base. When a global qualification bit is set, a match also requires address bits 15 to 12 to be zero. A two-flop reset synchronizer releases the asynchronous active-low reset on a clock edge.

Top module: `io_base_decoder`

## Requirements
- R1: After reset both bases read back 0x00 in both bytes, both activation bits and the qualification bit read 0, and neither select is asserted for any address.
- R2: A write with cfg_wr high at index 0x60 loads the high byte of the base and a write at index 0x61 loads the low byte, for the device chosen by cfg_dev (0 = runtime window, 1 = port pair). Each byte reads back at its own index. Base bits below the boundary read back as 0 whatever was written: bits 6..0 for the runtime window and bit 0 for the port pair.
- R3: The runtime window hits when io_valid is high, the device is active, its base is in range, and io_addr[11:7] equals base[11:7]. rt_sel is then high and rt_off equals io_addr[6:0].
- R4: The port pair hits when io_valid is high, the device is active, its base is in range, and io_addr[11:1] equals base[11:1]. port_sel is then high and port_off equals io_addr[0], where 0 is the data port and 1 is the status/command port.
- R5: With the qualification bit clear, io_addr[15:12] is ignored, so an address that differs from a window only in those bits still hits.
- R6: Bit 6 of global register index 0x24, written regardless of cfg_dev and read back at bit 6, is the qualification bit. While it is 1, no select is asserted unless io_addr[15:12] is zero.
- R7: A runtime base above 0x0F7F, or a port base below 0x0100 or above 0x0FFE, disables decoding for that device.
- R8: Bit 0 of index 0x30, per device as chosen by cfg_dev, activates the device. An inactive device never asserts its select, and no select is asserted while io_valid is low.
- R9: At most one select is asserted in any cycle. When both windows contain the address, rt_sel wins and port_sel stays low.
- R10: rt_off and port_off are 0 whenever their select is low, and reads at any other index return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_dev | input | 1 | Target logical device (0 runtime, 1 port pair) |
| cfg_idx | input | 8 | Configuration register index |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Readback of the register at cfg_idx for cfg_dev |
| io_valid | input | 1 | Host I/O cycle present |
| io_addr | input | 16 | Host I/O address |
| rt_sel | output | 1 | Runtime window selected |
| rt_off | output | 7 | Offset inside the runtime window |
| port_sel | output | 1 | Port pair selected |
| port_off | output | 1 | Port offset (0 data, 1 status/command) |

## Verification
The assertions check these rules on every cycle: the selects never both assert, a select needs a valid cycle and an active device, the qualification rule holds on the upper address bits, offsets equal the low address bits under a select and are zero without one, and the aligned low base bits always read back as zero. Other behaviour can only be shown by the bench's scenarios, which a reference model follows clock by clock. This covers the range limits at their exact edges, aliasing through the upper nibble when qualification is off, the overlap case in which the runtime window wins, and the byte-wise loading of a base.

// File: rtl/iobd_pkg.sv
package iobd_pkg;
  localparam int          BASE_W     = 16;
  localparam logic [7:0]  IDX_BASE_HI = 8'h60;
  localparam logic [7:0]  IDX_BASE_LO = 8'h61;
  localparam logic [7:0]  IDX_ACTIVE  = 8'h30;
  localparam logic [7:0]  IDX_GLOBAL  = 8'h24;
  localparam int          QUAL_BIT    = 6;

  typedef enum logic {
    DEV_RUNTIME = 1'b0,
    DEV_PORT    = 1'b1
  } dev_e;
endpackage

// File: rtl/iobd_base_reg.sv
module iobd_base_reg
  import iobd_pkg::*;
#(
  parameter int   ALIGN_BITS = 7,
  parameter dev_e DEV_ID     = DEV_RUNTIME
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_dev,
  input  logic [7:0]        wr_idx,
  input  logic [7:0]        wr_data,
  output logic [BASE_W-1:0] base_q,
  output logic              act_q
);
  localparam logic [BASE_W-1:0] KEEP_MASK = {BASE_W{1'b1}} << ALIGN_BITS;

  logic              hit;
  logic              base_en;
  logic              act_en;
  logic [BASE_W-1:0] base_d;
  logic              act_d;

  always_comb begin
    hit     = wr_en && (wr_dev == DEV_ID);
    base_en = hit && ((wr_idx == IDX_BASE_HI) || (wr_idx == IDX_BASE_LO));
    act_en  = hit && (wr_idx == IDX_ACTIVE);
    base_d  = base_q;
    if (wr_idx == IDX_BASE_HI) base_d[15:8] = wr_data;
    else                       base_d[7:0]  = wr_data;
    base_d  = base_d & KEEP_MASK;
    act_d   = wr_data[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (base_en) begin
      base_q <= base_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
    end else if (act_en) begin
      act_q <= act_d;
    end
  end
endmodule

// File: rtl/iobd_window_match.sv
module iobd_window_match
  import iobd_pkg::*;
#(
  parameter int              ALIGN_BITS = 7,
  parameter int              DEC_W      = 12,
  parameter logic [BASE_W-1:0] BASE_MIN = 16'h0000,
  parameter logic [BASE_W-1:0] BASE_MAX = 16'h0F7F
) (
  input  logic                  io_valid,
  input  logic [BASE_W-1:0]     io_addr,
  input  logic [BASE_W-1:0]     base,
  input  logic                  active,
  input  logic                  qual,
  output logic                  hit,
  output logic [ALIGN_BITS-1:0] off
);
  logic in_range;
  logic upper_ok;
  logic addr_eq;

  always_comb begin
    in_range = (base >= BASE_MIN) && (base <= BASE_MAX);
    upper_ok = !qual || (io_addr[BASE_W-1:DEC_W] == '0);
    addr_eq  = (io_addr[DEC_W-1:ALIGN_BITS] == base[DEC_W-1:ALIGN_BITS]);
    hit      = io_valid && active && in_range && upper_ok && addr_eq;
    off      = io_addr[ALIGN_BITS-1:0];
  end
endmodule

// File: rtl/io_base_decoder.sv
module io_base_decoder
  import iobd_pkg::*;
#(
  parameter int RT_ALIGN = 7,
  parameter int PT_ALIGN = 1,
  parameter int DEC_W    = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr,
  input  logic                cfg_dev,
  input  logic [7:0]          cfg_idx,
  input  logic [7:0]          cfg_wdata,
  output logic [7:0]          cfg_rdata,
  input  logic                io_valid,
  input  logic [BASE_W-1:0]   io_addr,
  output logic                rt_sel,
  output logic [RT_ALIGN-1:0] rt_off,
  output logic                port_sel,
  output logic [PT_ALIGN-1:0] port_off
);
  logic [1:0]        sync_q;
  logic              rst_sync_n;
  logic              qual_q;
  logic              qual_en;
  logic              qual_d;
  logic [BASE_W-1:0] rt_base;
  logic [BASE_W-1:0] pt_base;
  logic              rt_act;
  logic              pt_act;
  logic              rt_hit;
  logic              pt_hit;
  logic [RT_ALIGN-1:0] rt_raw_off;
  logic [PT_ALIGN-1:0] pt_raw_off;
  logic [BASE_W-1:0] sel_base;
  logic              sel_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end
  assign rst_sync_n = sync_q[1];

  always_comb begin
    qual_en = cfg_wr && (cfg_idx == IDX_GLOBAL);
    qual_d  = cfg_wdata[QUAL_BIT];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      qual_q <= 1'b0;
    end else if (qual_en) begin
      qual_q <= qual_d;
    end
  end

  iobd_base_reg #(.ALIGN_BITS(RT_ALIGN), .DEV_ID(DEV_RUNTIME)) u_rt_reg (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(cfg_wr), .wr_dev(cfg_dev),
    .wr_idx(cfg_idx), .wr_data(cfg_wdata), .base_q(rt_base), .act_q(rt_act)
  );

  iobd_base_reg #(.ALIGN_BITS(PT_ALIGN), .DEV_ID(DEV_PORT)) u_pt_reg (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(cfg_wr), .wr_dev(cfg_dev),
    .wr_idx(cfg_idx), .wr_data(cfg_wdata), .base_q(pt_base), .act_q(pt_act)
  );

  iobd_window_match #(.ALIGN_BITS(RT_ALIGN), .DEC_W(DEC_W),
                      .BASE_MIN(16'h0000), .BASE_MAX(16'h0F7F)) u_rt_match (
    .io_valid(io_valid), .io_addr(io_addr), .base(rt_base), .active(rt_act),
    .qual(qual_q), .hit(rt_hit), .off(rt_raw_off)
  );

  iobd_window_match #(.ALIGN_BITS(PT_ALIGN), .DEC_W(DEC_W),
                      .BASE_MIN(16'h0100), .BASE_MAX(16'h0FFE)) u_pt_match (
    .io_valid(io_valid), .io_addr(io_addr), .base(pt_base), .active(pt_act),
    .qual(qual_q), .hit(pt_hit), .off(pt_raw_off)
  );

  always_comb begin
    rt_sel   = rt_hit;
    port_sel = pt_hit && !rt_hit;
    rt_off   = rt_sel   ? rt_raw_off : '0;
    port_off = port_sel ? pt_raw_off : '0;
  end

  always_comb begin
    sel_base = (cfg_dev == DEV_PORT) ? pt_base : rt_base;
    sel_act  = (cfg_dev == DEV_PORT) ? pt_act  : rt_act;
    cfg_rdata = 8'h00;
    case (cfg_idx)
      IDX_BASE_HI: cfg_rdata = sel_base[15:8];
      IDX_BASE_LO: cfg_rdata = sel_base[7:0];
      IDX_ACTIVE:  cfg_rdata = {7'b0, sel_act};
      IDX_GLOBAL:  cfg_rdata[QUAL_BIT] = qual_q;
      default:     cfg_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/iobd_checker.sv
module iobd_checker
  import iobd_pkg::*;
#(
  parameter int RT_ALIGN = 7,
  parameter int PT_ALIGN = 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                io_valid,
  input logic [BASE_W-1:0]   io_addr,
  input logic                rt_sel,
  input logic [RT_ALIGN-1:0] rt_off,
  input logic                port_sel,
  input logic [PT_ALIGN-1:0] port_off,
  input logic                qual_q,
  input logic                rt_act,
  input logic                pt_act,
  input logic                cfg_dev,
  input logic [7:0]          cfg_idx,
  input logic [7:0]          cfg_rdata
);
  localparam logic [7:0] RT_LOW_MASK = 8'((16'(1) << RT_ALIGN) - 16'(1));

  // R9
  one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rt_sel && port_sel));

  // R8
  sel_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_sel || port_sel) |-> io_valid);

  // R8
  sel_needs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_sel |-> rt_act) and (port_sel |-> pt_act));

  // R6
  qual_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (qual_q && (rt_sel || port_sel)) |-> (io_addr[15:12] == 4'h0));

  // R3
  rt_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rt_sel |-> (rt_off == io_addr[RT_ALIGN-1:0]));

  // R4
  port_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_sel |-> (port_off == io_addr[PT_ALIGN-1:0]));

  // R10
  idle_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((!rt_sel) |-> (rt_off == '0)) and ((!port_sel) |-> (port_off == '0)));

  // R2
  low_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_idx == IDX_BASE_LO) && (cfg_dev == DEV_RUNTIME)) |->
      ((cfg_rdata & RT_LOW_MASK) == 8'h00));
endmodule

bind io_base_decoder iobd_checker #(.RT_ALIGN(RT_ALIGN), .PT_ALIGN(PT_ALIGN)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .io_valid(io_valid), .io_addr(io_addr),
  .rt_sel(rt_sel), .rt_off(rt_off), .port_sel(port_sel), .port_off(port_off),
  .qual_q(qual_q), .rt_act(rt_act), .pt_act(pt_act), .cfg_dev(cfg_dev),
  .cfg_idx(cfg_idx), .cfg_rdata(cfg_rdata)
);

// File: tb/io_base_decoder_test.sv
module io_base_decoder_test;
  logic        clk;
  logic        rst_n;
  logic        cfg_wr;
  logic        cfg_dev;
  logic [7:0]  cfg_idx;
  logic [7:0]  cfg_wdata;
  logic [7:0]  cfg_rdata;
  logic        io_valid;
  logic [15:0] io_addr;
  logic        rt_sel;
  logic [6:0]  rt_off;
  logic        port_sel;
  logic [0:0]  port_off;

  int    checks = 0;
  int    failures = 0;
  bit    done = 0;
  string cur_tag = "R1";

  int m_rt_base, m_pt_base;
  bit m_rt_act, m_pt_act, m_qual;

  io_base_decoder uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_dev(cfg_dev),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .io_valid(io_valid), .io_addr(io_addr), .rt_sel(rt_sel), .rt_off(rt_off),
    .port_sel(port_sel), .port_off(port_off)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // reference model state
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rt_base = 0; m_pt_base = 0; m_rt_act = 0; m_pt_act = 0; m_qual = 0;
    end else if (cfg_wr) begin
      if (cfg_idx == 8'h24) m_qual = cfg_wdata[6];
      else if (cfg_idx == 8'h30) begin
        if (cfg_dev) m_pt_act = cfg_wdata[0]; else m_rt_act = cfg_wdata[0];
      end else if (cfg_idx == 8'h60 || cfg_idx == 8'h61) begin
        int b;
        b = cfg_dev ? m_pt_base : m_rt_base;
        if (cfg_idx == 8'h60) b = (int'(cfg_wdata) * 256) + (b % 256);
        else                  b = (b / 256) * 256 + int'(cfg_wdata);
        if (cfg_dev) m_pt_base = b - (b % 2);
        else         m_rt_base = b - (b % 128);
      end
    end
  end

  function automatic int exp_rdata();
    int b;
    b = cfg_dev ? m_pt_base : m_rt_base;
    case (cfg_idx)
      8'h60: return b / 256;
      8'h61: return b % 256;
      8'h30: return cfg_dev ? int'(m_pt_act) : int'(m_rt_act);
      8'h24: return m_qual ? 64 : 0;
      default: return 0;
    endcase
  endfunction

  task automatic cmp(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", cur_tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      int  a, low;
      bit  up_ok, rs, ps;
      int  ro, po;
      a     = int'(io_addr);
      low   = a % 4096;
      up_ok = !m_qual || (a / 4096 == 0);
      rs = io_valid && m_rt_act && (m_rt_base <= 'h0F7F) && up_ok &&
           (low >= m_rt_base) && (low < m_rt_base + 128);
      ps = io_valid && m_pt_act && (m_pt_base >= 'h0100) && (m_pt_base <= 'h0FFE) &&
           up_ok && (low == m_pt_base || low == m_pt_base + 1) && !rs;
      ro = rs ? low - m_rt_base : 0;
      po = ps ? low - m_pt_base : 0;
      cmp("rt_sel", int'(rt_sel), int'(rs));
      cmp("rt_off", int'(rt_off), ro);
      cmp("port_sel", int'(port_sel), int'(ps));
      cmp("port_off", int'(port_off), po);
      cmp("cfg_rdata", int'(cfg_rdata), exp_rdata());
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input bit dev, input logic [7:0] idx, input logic [7:0] data);
    tick();
    cfg_wr = 1'b1; cfg_dev = dev; cfg_idx = idx; cfg_wdata = data;
    tick();
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input bit dev, input logic [7:0] idx);
    cfg_dev = dev; cfg_idx = idx;
    tick();
  endtask

  task automatic acc(input logic [15:0] a, input bit v = 1'b1);
    io_valid = v; io_addr = a;
    tick();
    io_valid = 1'b0;
  endtask

  task automatic set_base(input bit dev, input logic [15:0] b);
    wr(dev, 8'h60, b[15:8]);
    wr(dev, 8'h61, b[7:0]);
  endtask

  initial begin
    rst_n = 1'b0; cfg_wr = 0; cfg_dev = 0; cfg_idx = 8'h00; cfg_wdata = 0;
    io_valid = 0; io_addr = 16'h0000;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) tick();

    cur_tag = "R1";
    rd(0, 8'h60); rd(0, 8'h61); rd(1, 8'h60); rd(1, 8'h61); rd(0, 8'h30); rd(1, 8'h24);
    acc(16'h0000); acc(16'h0001); acc(16'h0100);

    cur_tag = "R2";
    wr(0, 8'h60, 8'h02); wr(0, 8'h61, 8'hFF);
    rd(0, 8'h60); rd(0, 8'h61);
    wr(1, 8'h60, 8'h03); wr(1, 8'h61, 8'h41);
    rd(1, 8'h60); rd(1, 8'h61); rd(0, 8'h61);

    cur_tag = "R8";
    acc(16'h0285); acc(16'h0340);
    wr(0, 8'h30, 8'h01); wr(1, 8'h30, 8'h01);
    rd(0, 8'h30); rd(1, 8'h30);
    acc(16'h0285, 1'b0); acc(16'h0341, 1'b0);

    cur_tag = "R3";
    acc(16'h0280); acc(16'h02FF); acc(16'h027F); acc(16'h0300); acc(16'h02A5);

    cur_tag = "R4";
    acc(16'h0340); acc(16'h0341); acc(16'h0342); acc(16'h033F);

    cur_tag = "R5";
    acc(16'hA285); acc(16'hF341);

    cur_tag = "R6";
    wr(0, 8'h24, 8'h40); rd(1, 8'h24);
    acc(16'hA285); acc(16'h1341); acc(16'h0285); acc(16'h0341);
    wr(1, 8'h24, 8'h00); acc(16'hA285);

    cur_tag = "R7";
    set_base(0, 16'h0F80); acc(16'h0F80); acc(16'h0FFF);
    set_base(0, 16'h1000); acc(16'h0000); acc(16'h1000);
    set_base(0, 16'h0F00); acc(16'h0F7F); acc(16'h0F00);
    set_base(1, 16'h00FE); acc(16'h00FE); acc(16'h00FF);
    set_base(1, 16'h0100); acc(16'h0100); acc(16'h0101);
    set_base(1, 16'h0FFE); acc(16'h0FFF); acc(16'h0FFE);
    set_base(1, 16'h1000); acc(16'h0000);

    cur_tag = "R9";
    set_base(0, 16'h0300); set_base(1, 16'h0340);
    acc(16'h0340); acc(16'h0341); acc(16'h037F);
    wr(0, 8'h30, 8'h00); acc(16'h0341);

    cur_tag = "R10";
    rd(0, 8'h55); rd(1, 8'hFF);
    acc(16'h0500); acc(16'h0341, 1'b0);

    tick();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog %s: actual=hung expected=finished", cur_tag);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule